// File: doc/BRIEF.md
# Write-Back DMA for Engine Output Streams

The block takes the byte stream that a processing engine produces and stores it in memory. Each target buffer is described by a start address, a byte count and two flags. One flag is discard. The other is an end-of-block event enable. A start pulse picks one of two ways to supply these buffers. In direct mode the buffer comes from a configuration address and a configuration length word, and only that one buffer is filled. In chain mode the configuration address points at the first of a linked list of in-memory descriptors. The descriptor layout is the same one the fetch side uses.

The block reads each descriptor through a simple request/acknowledge read port. During that read, the input stream is held off. It then writes one byte per accepted input beat through a valid/ready write port. Data runs on across descriptor boundaries without losing any bytes. When a buffer is used up, the block can pulse a per-block event. On the last buffer it pulses a stopped event and drops its busy and waiting status. A stop request turns the current buffer into the last one. Any byte that arrives while the block is idle is taken and thrown away, and a sticky overflow flag is set.

Top module: `wb_dma_writer`

## Requirements
- R1: After reset, and whenever the block is idle, `busy`, `waiting`, `rd_req` and `wr_valid` are low and `in_ready` is high. After reset, `overflow` and both event outputs are also low.
- R2: A `start` pulse taken while idle raises both `busy` and `waiting` in the following cycle.
- R3: A byte accepted while idle is dropped with no write. `overflow` then goes high and stays high until reset.
- R4: In direct mode (`chain_mode`=0), `cfg_addr` is the buffer address. `cfg_len[27:0]` is the byte count and `cfg_len[31]` selects discard; bits 30..28 have no effect. The block is always the last one and never raises an end-of-block event.
- R5: Bytes that are not discarded are written in arrival order to consecutive byte addresses, one write per accepted beat. `wr_valid` is only raised together with an offered input byte.
- R6: In a discard block each accepted byte lowers the remaining count and advances the address, but no write is issued.
- R7: In chain mode a descriptor at pointer P is read as three words. P+0 is the buffer address. P+4 holds the next pointer, with bit 0 as the stop flag. P+8 holds the count in bits 27:0, discard in bit 30 and event enable in bit 31. The tag word at P+12 is never read. The low two bits of a next pointer are cleared before use.
- R8: When a block's count is used up and its event enable is set, `evt_block` pulses for one cycle.
- R9: When a used-up block is marked stop, `evt_stopped` pulses. `busy` and `waiting` are low in that same cycle.
- R10: When a used-up block is not marked stop, the next descriptor is loaded and the stream continues into the new buffer with no byte lost. `in_ready` is low while a descriptor read is pending.
- R11: A `stop_req` while busy makes the block in progress, or the block being loaded, the last one.
- R12: A block with a zero count completes, including its events, without taking any input byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, taken only while idle |
| chain_mode | input | 1 | 0: direct buffer, 1: descriptor chain |
| cfg_addr | input | 32 | Direct buffer address or first descriptor pointer |
| cfg_len | input | 32 | Direct count [27:0] and discard [31] |
| stop_req | input | 1 | End the job after the current block |
| in_valid | input | 1 | Input byte offered |
| in_data | input | DATA_W | Input byte |
| in_ready | output | 1 | Input byte taken |
| wr_valid | output | 1 | Memory write request |
| wr_addr | output | 32 | Memory write byte address |
| wr_data | output | DATA_W | Memory write byte |
| wr_ready | input | 1 | Memory write accepted |
| rd_req | output | 1 | Descriptor word read request |
| rd_addr | output | 32 | Descriptor word address |
| rd_ack | input | 1 | Read data valid, request done |
| rd_data | input | 32 | Descriptor word |
| evt_block | output | 1 | End-of-block event pulse |
| evt_stopped | output | 1 | Stopped event pulse |
| busy | output | 1 | Job in progress |
| waiting | output | 1 | Job expects more data |
| overflow | output | 1 | Sticky flag for dropped data |

## Verification
The hardest case to reach is a chain in which a zero-count block sits between data blocks, a discard block follows it, and the next-pointer word carries a stray low bit. All of this must happen while the memory write port stalls and the descriptor port acknowledges only every other cycle. The bench builds such a chain in its descriptor memory and streams bytes continuously. The ordered write and event queues then expose any byte that is lost or duplicated at a boundary. The stop request is driven while the first descriptor is still being read, so that the pending-stop path is exercised rather than the stop flag held in the descriptor.

// File: rtl/wb_dma_pkg.sv
package wb_dma_pkg;

    localparam int unsigned WORD_W             = 32;
    localparam int unsigned LEN_W              = 28;
    localparam int unsigned DESC_WORDS         = 3;
    localparam int unsigned DESC_STOP_BIT      = 0;
    localparam int unsigned DESC_DISCARD_BIT   = 30;
    localparam int unsigned DESC_INTEN_BIT     = 31;
    localparam int unsigned DIRECT_DISCARD_BIT = 31;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_XFER = 2'd2
    } wb_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] buf_addr;
        logic [WORD_W-1:0] next_ptr;
        logic              stop;
        logic [LEN_W-1:0]  len;
        logic              discard;
        logic              int_en;
    } wb_desc_t;

endpackage

// File: rtl/wb_dma_desc_loader.sv
module wb_dma_desc_loader
    import wb_dma_pkg::*;
#(
    parameter int unsigned N_WORDS = DESC_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [WORD_W-1:0] base,
    output logic              rd_req,
    output logic [WORD_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [WORD_W-1:0] rd_data,
    output logic              done,
    output wb_desc_t          desc
);
    localparam int unsigned IDX_W = $clog2(N_WORDS + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

    typedef struct packed {
        logic                           active;
        logic [IDX_W-1:0]               idx;
        logic [WORD_W-1:0]              base;
        logic                           done;
        logic [N_WORDS-1:0][WORD_W-1:0] words;
    } ld_t;

    ld_t ld_d, ld_q;

    always_comb begin
        ld_d      = ld_q;
        ld_d.done = 1'b0;
        if (go) begin
            ld_d.active = 1'b1;
            ld_d.idx    = '0;
            ld_d.base   = {base[WORD_W-1:2], 2'b00};
        end else if (ld_q.active && rd_ack) begin
            ld_d.words[ld_q.idx] = rd_data;
            if (ld_q.idx == LAST_IDX) begin
                ld_d.active = 1'b0;
                ld_d.done   = 1'b1;
            end else begin
                ld_d.idx = ld_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_q <= '0;
        end else begin
            ld_q <= ld_d;
        end
    end

    assign rd_req  = ld_q.active;
    assign rd_addr = ld_q.base + (WORD_W'(ld_q.idx) << 2);
    assign done    = ld_q.done;

    always_comb begin
        desc          = '0;
        desc.buf_addr = ld_q.words[0];
        desc.next_ptr = {ld_q.words[1][WORD_W-1:2], 2'b00};
        desc.stop     = ld_q.words[1][DESC_STOP_BIT];
        desc.len      = ld_q.words[2][LEN_W-1:0];
        desc.discard  = ld_q.words[2][DESC_DISCARD_BIT];
        desc.int_en   = ld_q.words[2][DESC_INTEN_BIT];
    end

endmodule

// File: rtl/wb_dma_beat_path.sv
module wb_dma_beat_path
    import wb_dma_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              idle,
    input  logic              active,
    input  logic              discard,
    input  logic [WORD_W-1:0] cur_addr,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              wr_ready,
    output logic              in_ready,
    output logic              wr_valid,
    output logic [WORD_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              beat,
    output logic              drop
);
    always_comb begin
        wr_valid = active && !discard && in_valid;
        wr_addr  = cur_addr;
        wr_data  = in_data;
        in_ready = idle || (active && (discard || wr_ready));
        beat     = active && in_valid && in_ready;
        drop     = idle && in_valid;
    end

endmodule

// File: rtl/wb_dma_writer.sv
module wb_dma_writer
    import wb_dma_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned N_WORDS = DESC_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              chain_mode,
    input  logic [WORD_W-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_len,
    input  logic              stop_req,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              wr_valid,
    output logic [WORD_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ready,
    output logic              rd_req,
    output logic [WORD_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [WORD_W-1:0] rd_data,
    output logic              evt_block,
    output logic              evt_stopped,
    output logic              busy,
    output logic              waiting,
    output logic              overflow
);
    typedef struct packed {
        wb_state_e         state;
        logic [WORD_W-1:0] addr;
        logic [LEN_W-1:0]  rem;
        logic              discard;
        logic              int_en;
        logic              stop;
        logic [WORD_W-1:0] next_ptr;
        logic              busy;
        logic              waiting;
        logic              stop_pend;
        logic              overflow;
        logic              evt_blk;
        logic              evt_stp;
    } ctl_t;

    ctl_t              c_d, c_q;
    logic              ld_go;
    logic [WORD_W-1:0] ld_base;
    logic              ld_done;
    wb_desc_t          ld_desc;
    logic              beat, drop, path_active;

    assign path_active = (c_q.state == ST_XFER) && (c_q.rem != '0);

    wb_dma_desc_loader #(.N_WORDS(N_WORDS)) u_loader (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (ld_go),
        .base    (ld_base),
        .rd_req  (rd_req),
        .rd_addr (rd_addr),
        .rd_ack  (rd_ack),
        .rd_data (rd_data),
        .done    (ld_done),
        .desc    (ld_desc)
    );

    wb_dma_beat_path #(.DATA_W(DATA_W)) u_path (
        .idle     (c_q.state == ST_IDLE),
        .active   (path_active),
        .discard  (c_q.discard),
        .cur_addr (c_q.addr),
        .in_valid (in_valid),
        .in_data  (in_data),
        .wr_ready (wr_ready),
        .in_ready (in_ready),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .beat     (beat),
        .drop     (drop)
    );

    always_comb begin
        c_d         = c_q;
        c_d.evt_blk = 1'b0;
        c_d.evt_stp = 1'b0;
        ld_go       = 1'b0;
        ld_base     = c_q.next_ptr;

        if (drop) begin
            c_d.overflow = 1'b1;
        end
        if (stop_req && c_q.busy) begin
            c_d.stop_pend = 1'b1;
        end

        unique case (c_q.state)
            ST_IDLE: begin
                if (start) begin
                    c_d.busy      = 1'b1;
                    c_d.waiting   = 1'b1;
                    c_d.stop_pend = 1'b0;
                    if (chain_mode) begin
                        ld_go     = 1'b1;
                        ld_base   = cfg_addr;
                        c_d.state = ST_LOAD;
                    end else begin
                        c_d.addr    = cfg_addr;
                        c_d.rem     = cfg_len[LEN_W-1:0];
                        c_d.discard = cfg_len[DIRECT_DISCARD_BIT];
                        c_d.stop    = 1'b1;
                        c_d.int_en  = 1'b0;
                        c_d.state   = ST_XFER;
                    end
                end
            end
            ST_LOAD: begin
                if (ld_done) begin
                    c_d.addr     = ld_desc.buf_addr;
                    c_d.rem      = ld_desc.len;
                    c_d.discard  = ld_desc.discard;
                    c_d.int_en   = ld_desc.int_en;
                    c_d.stop     = ld_desc.stop;
                    c_d.next_ptr = ld_desc.next_ptr;
                    c_d.state    = ST_XFER;
                end
            end
            ST_XFER: begin
                if (beat) begin
                    c_d.rem  = c_q.rem - LEN_W'(1);
                    c_d.addr = c_q.addr + WORD_W'(1);
                end else if (c_q.rem == '0) begin
                    c_d.evt_blk = c_q.int_en;
                    if (c_q.stop || c_q.stop_pend || stop_req) begin
                        c_d.evt_stp = 1'b1;
                        c_d.busy    = 1'b0;
                        c_d.waiting = 1'b0;
                        c_d.state   = ST_IDLE;
                    end else begin
                        ld_go     = 1'b1;
                        ld_base   = c_q.next_ptr;
                        c_d.state = ST_LOAD;
                    end
                end
            end
            default: begin
                c_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.state <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign evt_block   = c_q.evt_blk;
    assign evt_stopped = c_q.evt_stp;
    assign busy        = c_q.busy;
    assign waiting     = c_q.waiting;
    assign overflow    = c_q.overflow;

endmodule

// File: rtl/wb_dma_writer_chk.sv
module wb_dma_writer_chk
    import wb_dma_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              in_valid,
    input logic              in_ready,
    input logic              wr_valid,
    input logic              rd_req,
    input logic [WORD_W-1:0] rd_addr,
    input logic              evt_block,
    input logic              evt_stopped,
    input logic              busy,
    input logic              waiting,
    input logic              overflow
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_req && !wr_valid && !waiting));

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && waiting));

    p_no_overflow_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    p_write_has_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (in_valid && busy));

    p_word_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_addr[1:0] == 2'b00));

    p_block_evt_in_job_r8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_block |-> $past(busy));

    p_stopped_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_stopped |-> (!busy && !waiting && $past(busy)));

    p_hold_on_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !in_ready);

endmodule

bind wb_dma_writer wb_dma_writer_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .wr_valid    (wr_valid),
    .rd_req      (rd_req),
    .rd_addr     (rd_addr),
    .evt_block   (evt_block),
    .evt_stopped (evt_stopped),
    .busy        (busy),
    .waiting     (waiting),
    .overflow    (overflow)
);

// File: tb/wb_dma_writer_tb_top.sv
module wb_dma_writer_tb_top;
    import wb_dma_pkg::*;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, chain_mode = 1'b0, stop_req = 1'b0;
    logic [31:0] cfg_addr = '0, cfg_len = '0;
    logic        in_valid = 1'b0, in_ready;
    logic [7:0]  in_data = '0;
    logic        wr_valid, wr_ready = 1'b1;
    logic [31:0] wr_addr;
    logic [7:0]  wr_data;
    logic        rd_req, rd_ack = 1'b0;
    logic [31:0] rd_addr, rd_data = '0;
    logic        evt_block, evt_stopped, busy, waiting, overflow;

    always #2 clk = ~clk;

    wb_dma_writer dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .chain_mode(chain_mode),
        .cfg_addr(cfg_addr), .cfg_len(cfg_len), .stop_req(stop_req),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .evt_block(evt_block), .evt_stopped(evt_stopped),
        .busy(busy), .waiting(waiting), .overflow(overflow)
    );

    int unsigned n_cmp = 0, n_bad = 0, cyc = 0;
    byte unsigned src_q[$];
    logic [31:0]  exp_a[$];
    byte unsigned exp_d[$];
    int           exp_ev[$];
    string        exp_tag[$];
    logic [31:0]  dmem [int unsigned];
    bit           feed_en = 0, stall_wr = 0, start_v = 0, stop_v = 0;
    byte unsigned pat = 8'h11;

    function automatic void finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        start    = start_v;  start_v = 0;
        stop_req = stop_v;   stop_v  = 0;
        in_valid = feed_en && (src_q.size() > 0);
        in_data  = in_valid ? src_q[0] : 8'h00;
        wr_ready = !(stall_wr && (cyc % 3 == 1));
        rd_ack   = rd_req && (cyc % 2 == 0);
        rd_data  = dmem.exists(rd_addr) ? dmem[rd_addr] : 32'hDEAD_BEEF;
        #1;
        if (wr_valid && wr_ready) begin
            if (exp_a.size() == 0) chk("R5", "unexpected write", wr_addr, 0);
            else begin
                chk("R5", "write addr", wr_addr, exp_a.pop_front());
                chk("R5", "write data", wr_data, exp_d.pop_front());
            end
        end
        if (in_valid && in_ready) void'(src_q.pop_front());
        if (rd_req) begin
            chk("R7", "tag word read", rd_addr[3:2] == 2'd3, 0);
            chk("R10", "ready during load", in_ready, 0);
        end
        if (!busy) chk("R1", "write while idle", wr_valid, 0);
        if (evt_block) begin
            if (exp_ev.size() == 0) chk("R8", "unexpected block event", 1, 0);
            else begin
                string t = exp_tag.pop_front();
                chk(t, "block event", exp_ev.pop_front(), 1);
            end
        end
        if (evt_stopped) begin
            if (exp_ev.size() == 0) chk("R9", "unexpected stop event", 1, 0);
            else begin
                string t = exp_tag.pop_front();
                chk(t, "stop event", exp_ev.pop_front(), 2);
            end
            chk("R9", "busy at stop", busy, 0);
            chk("R9", "waiting at stop", waiting, 0);
        end
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    endtask

    // Expected stream of one block: feeds bytes, queues writes and events.
    task automatic expect_block(input logic [31:0] a, input int unsigned len, input bit disc,
                                input bit inten, input bit last, input string req);
        for (int i = 0; i < int'(len); i++) begin
            src_q.push_back(pat);
            if (!disc) begin
                exp_a.push_back(a + 32'(i));
                exp_d.push_back(pat);
            end
            pat = pat + 8'd7;
        end
        if (inten) begin exp_ev.push_back(1); exp_tag.push_back(req); end
        if (last)  begin exp_ev.push_back(2); exp_tag.push_back(req); end
    endtask

    task automatic put_desc(input logic [31:0] p, input logic [31:0] buf_a, input logic [31:0] nxt,
                            input bit stop, input int unsigned len, input bit disc, input bit inten);
        dmem[p]      = buf_a;
        dmem[p + 4]  = nxt | {31'd0, stop};
        dmem[p + 8]  = {inten, disc, 2'b01, 28'(len)};
        dmem[p + 12] = 32'hA5A5_0000 | p;
    endtask

    task automatic launch(input bit chain, input logic [31:0] a, input logic [31:0] l);
        chain_mode = chain; cfg_addr = a; cfg_len = l;
        start_v = 1;
        tick();
        feed_en = 1;
        tick();
        chk("R2", "busy after start", busy, 1);
        chk("R2", "waiting after start", waiting, 1);
    endtask

    task automatic run_idle(input string req);
        int n = 0;
        while (busy && n < 400) begin tick(); n++; end
        repeat (2) tick();
        chk(req, "job finished", busy, 0);
        chk(req, "writes left", exp_a.size(), 0);
        chk(req, "events left", exp_ev.size(), 0);
        chk(req, "bytes left", src_q.size(), 0);
        feed_en = 0;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1", "busy", busy, 0);
        chk("R1", "waiting", waiting, 0);
        chk("R1", "overflow", overflow, 0);
        chk("R1", "rd_req", rd_req, 0);
        chk("R1", "in_ready idle", in_ready, 1);
        chk("R1", "events", {evt_block, evt_stopped}, 0);

        // R4/R5: direct mode with stray bits 29 in the length word and write stalls
        stall_wr = 1;
        expect_block(32'h0000_1000, 5, 0, 0, 1, "R4");
        launch(0, 32'h0000_1000, 32'h2000_0005);
        run_idle("R4");

        // R6: direct discard
        expect_block(32'h0000_2000, 4, 1, 0, 1, "R6");
        launch(0, 32'h0000_2000, 32'h8000_0004);
        run_idle("R6");

        // R7/R8/R10/R12: chain with zero-length and discard blocks, stray next-pointer bit
        put_desc(32'h100, 32'h5000, 32'h202, 0, 3, 0, 1);
        put_desc(32'h200, 32'h6000, 32'h300, 0, 0, 0, 1);
        put_desc(32'h300, 32'h7000, 32'h400, 0, 4, 1, 0);
        put_desc(32'h400, 32'h8000, 32'h000, 1, 5, 0, 1);
        expect_block(32'h5000, 3, 0, 1, 0, "R8");
        expect_block(32'h6000, 0, 0, 1, 0, "R12");
        expect_block(32'h7000, 4, 1, 0, 0, "R10");
        expect_block(32'h8000, 5, 0, 1, 1, "R7");
        launch(1, 32'h100, 32'h0);
        run_idle("R10");

        // R11: stop request during first load ends the chain after block one
        stall_wr = 0;
        put_desc(32'h900, 32'h9100, 32'hA00, 0, 3, 0, 0);
        put_desc(32'hA00, 32'hA100, 32'h000, 1, 2, 0, 1);
        expect_block(32'h9100, 3, 0, 0, 1, "R11");
        chain_mode = 1; cfg_addr = 32'h900;
        start_v = 1;
        tick();
        stop_v = 1;
        tick();
        feed_en = 1;
        run_idle("R11");
        chk("R3", "no overflow yet", overflow, 0);

        // R3: bytes while idle are dropped and the flag sticks
        src_q.push_back(8'hEE); src_q.push_back(8'hEF);
        feed_en = 1;
        repeat (4) tick();
        feed_en = 0;
        chk("R3", "idle bytes taken", src_q.size(), 0);
        chk("R3", "overflow set", overflow, 1);
        expect_block(32'h0000_3000, 1, 0, 0, 1, "R3");
        launch(0, 32'h0000_3000, 32'h0000_0001);
        run_idle("R3");
        chk("R3", "overflow sticky", overflow, 1);

        finish_run();
    end

endmodule